// File: doc/BRIEF.md
# Synchronous Burst Read Clock and Latency Controller

This block runs synchronous burst reads from an external NOR Flash or PSRAM. When it accepts a request, it drives the start address and the chip select. It also produces a memory clock, which is the system clock divided by a programmable ratio. An active-low address-valid strobe goes out with the address so that the memory latches it on the first rising edge of that clock.

The block then counts a programmable number of memory clock edges as the first-data latency. After that it samples one 16-bit word on each following rising edge. When the memory holds its active-low wait input low on such an edge, no word is taken on that edge. Each word leaves the block with a one-cycle valid pulse, and the final word of the burst also carries a last flag.

When the final word is in, the chip select is released and the memory clock stops. A programmable turnaround gap then runs before the block takes the next request. The requester supplies the burst length, minus one, together with the address. The clock ratio, latency and turnaround settings are captured at the moment the request is accepted.

Top module: `sbc_ctrl`

## Requirements
- R1: After reset, mem_cs_n=1, mem_adv_n=1, mem_clk=0, req_ready=1 and rd_valid=0.
- R2: A request is accepted in a cycle where req_valid=1 and req_ready=1. Call the cycle after acceptance cycle 1, and let D be the effective ratio and H = floor(D/2). In cycle c of the burst, mem_clk is 1 exactly when (H + c - 1) mod D < H. The clock therefore starts in its low phase, has period D, and for odd D its high phase is one cycle shorter than its low phase.
- R3: The effective ratio is cfg_div clamped to the range 2..16. A value below 2 behaves as 2 and a value above 16 behaves as 16.
- R4: mem_adv_n is 0 from cycle 1 through cycle R0+H-1, where R0 = D-H+1 is the cycle of the first rising edge. It returns to 1 at the falling phase after that edge. While mem_adv_n is 0, mem_addr equals the accepted req_addr.
- R5: The rising edge in cycle R0 is edge 0. Edge k falls in cycle R0+k*D. Data may be sampled only on edges with k >= L, where L is cfg_lat clamped to the range 2..17.
- R6: On such an edge, the word on mem_data is captured only when mem_wait_n=1. When mem_wait_n=0 on that edge, nothing is captured. mem_wait_n has no effect in any other cycle.
- R7: A word captured in cycle c appears on rd_data with rd_valid=1 in cycle c+1. A burst captures req_len_m1+1 words, and rd_last=1 only together with the final one.
- R8: mem_cs_n is 0 from cycle 1 through the cycle of the final capture. In the following cycle mem_cs_n is 1 and mem_clk is 0, and both stay so until the next acceptance.
- R9: req_ready is 0 from cycle 1 until cycle CL+T+1, where CL is the final capture cycle and T is the accepted cfg_turn (0..15). req_ready is 1 in cycle CL+T+1. Requests presented before then are ignored.
- R10: cfg_div, cfg_lat, cfg_turn, req_addr and req_len_m1 are used only in the accepting cycle. Changes to them during a burst or its turnaround have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Burst request |
| req_ready | output | 1 | High when a request can be accepted |
| req_addr | input | 26 | Start word address |
| req_len_m1 | input | 8 | Words in the burst, minus one |
| cfg_div | input | 5 | System clocks per memory clock (clamped to 2..16) |
| cfg_lat | input | 5 | First-data latency in memory clocks (clamped to 2..17) |
| cfg_turn | input | 4 | Turnaround gap in system clocks |
| mem_clk | output | 1 | Generated memory clock |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_adv_n | output | 1 | Active-low address-valid strobe |
| mem_addr | output | 26 | Address to memory |
| mem_wait_n | input | 1 | Active-low wait from memory |
| mem_data | input | 16 | Read data from memory |
| rd_valid | output | 1 | Captured word valid pulse |
| rd_data | output | 16 | Captured word |
| rd_last | output | 1 | Final word of the burst |

## Verification
Every result is timed from the acceptance cycle. The memory clock level, the strobe, the chip select and the ready flag in burst cycle c all follow closed formulas in D, H, L and T. A word sampled on an edge appears one cycle later, and ready returns exactly T+1 cycles after the final capture. The bench counts cycles after the acceptance edge, drives the wait and data inputs half a cycle before each edge, and compares every output once per cycle at the falling clock edge against its own model of these formulas. Settings and request inputs are changed at random during each burst, so the checks also confirm that those changes have no effect.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int DIV_MIN = 2;
  localparam int DIV_MAX = 16;
  localparam int LAT_MIN = 2;
  localparam int LAT_MAX = 17;
  localparam int DIV_W   = $clog2(DIV_MAX + 1);
  localparam int LAT_W   = $clog2(LAT_MAX + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_BURST, ST_TURN} sbc_state_t;

  function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] d);
    if (d < DIV_W'(DIV_MIN)) return DIV_W'(DIV_MIN);
    if (d > DIV_W'(DIV_MAX)) return DIV_W'(DIV_MAX);
    return d;
  endfunction

  function automatic logic [LAT_W-1:0] clamp_lat(input logic [LAT_W-1:0] l);
    if (l < LAT_W'(LAT_MIN)) return LAT_W'(LAT_MIN);
    if (l > LAT_W'(LAT_MAX)) return LAT_W'(LAT_MAX);
    return l;
  endfunction

  // Length of the high phase: the shorter half for odd ratios.
  function automatic logic [DIV_W-1:0] high_len(input logic [DIV_W-1:0] d);
    return d >> 1;
  endfunction
endpackage

// File: rtl/sbc_clkgen.sv
module sbc_clkgen
  import sbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             mem_clk,
  output logic             rise_evt,
  output logic             last_high
);
  logic [DIV_W-1:0] div_r;
  logic [DIV_W-1:0] hi_r;
  logic [DIV_W-1:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_r <= DIV_W'(DIV_MIN);
      hi_r  <= DIV_W'(1);
      ph    <= '0;
    end else if (start) begin
      div_r <= clamp_div(cfg_div);
      hi_r  <= high_len(clamp_div(cfg_div));
      ph    <= high_len(clamp_div(cfg_div));   // begin in the low phase
    end else if (run) begin
      ph <= (ph == div_r - DIV_W'(1)) ? '0 : ph + DIV_W'(1);
    end
  end

  assign mem_clk   = run && (ph < hi_r);
  assign rise_evt  = run && (ph == '0);
  assign last_high = run && (ph == hi_r - DIV_W'(1));

  // Rising edges are at least two system cycles apart.
  assert_rise_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> !rise_evt);
  // The running ratio always lies in the legal range.
  assert_div_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (div_r >= DIV_W'(DIV_MIN) && div_r <= DIV_W'(DIV_MAX)));
endmodule

// File: rtl/sbc_capture.sv
module sbc_capture #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              sample,
  input  logic [DATA_W-1:0] mem_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last,
  output logic              done_evt
);
  logic [LEN_W-1:0] len_r;
  logic [LEN_W-1:0] wcnt;

  assign done_evt = sample && (wcnt == len_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_r    <= '0;
      wcnt     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_last  <= 1'b0;
    end else begin
      rd_valid <= sample;
      if (start) begin
        len_r <= len_m1;
        wcnt  <= '0;
      end else if (sample) begin
        wcnt <= wcnt + LEN_W'(1);
      end
      if (sample) begin
        rd_data <= mem_data;
        rd_last <= done_evt;
      end
    end
  end

  // A last word is never followed at once by another word.
  assert_last_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_last) |=> !rd_valid);
endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8,
  parameter int TURN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len_m1,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [LAT_W-1:0]  cfg_lat,
  input  logic [TURN_W-1:0] cfg_turn,
  output logic              mem_clk,
  output logic              mem_cs_n,
  output logic              mem_adv_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_wait_n,
  input  logic [DATA_W-1:0] mem_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last
);
  sbc_state_t        state;
  logic              adv_q;
  logic [ADDR_W-1:0] addr_r;
  logic [LAT_W-1:0]  lat_r;
  logic [LAT_W-1:0]  edge_cnt;
  logic [TURN_W-1:0] turn_r;
  logic [TURN_W-1:0] tcnt;

  // Named internal events
  logic accept, run, rise_evt, last_high, data_edge, sample, done_evt;

  assign accept    = req_valid && (state == ST_IDLE);
  assign run       = (state == ST_BURST);
  assign data_edge = rise_evt && (edge_cnt == lat_r);
  assign sample    = data_edge && mem_wait_n;

  sbc_clkgen u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .run       (run),
    .cfg_div   (cfg_div),
    .mem_clk   (mem_clk),
    .rise_evt  (rise_evt),
    .last_high (last_high)
  );

  sbc_capture #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .len_m1   (req_len_m1),
    .sample   (sample),
    .mem_data (mem_data),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_last  (rd_last),
    .done_evt (done_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      adv_q    <= 1'b1;
      addr_r   <= '0;
      lat_r    <= LAT_W'(LAT_MIN);
      edge_cnt <= '0;
      turn_r   <= '0;
      tcnt     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_BURST;
          adv_q    <= 1'b0;
          addr_r   <= req_addr;
          lat_r    <= clamp_lat(cfg_lat);
          turn_r   <= cfg_turn;
          edge_cnt <= '0;
        end
        ST_BURST: begin
          if (!adv_q && last_high) adv_q <= 1'b1;   // release on falling phase
          if (rise_evt && edge_cnt < lat_r) edge_cnt <= edge_cnt + LAT_W'(1);
          if (done_evt) begin
            adv_q <= 1'b1;
            tcnt  <= turn_r;
            state <= (turn_r == '0) ? ST_IDLE : ST_TURN;
          end
        end
        ST_TURN: begin
          tcnt <= tcnt - TURN_W'(1);
          if (tcnt == TURN_W'(1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign mem_cs_n  = !run;
  assign mem_adv_n = adv_q;
  assign mem_addr  = addr_r;

  assert_adv_in_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> !mem_cs_n);
  assert_no_data_in_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_edge |-> mem_adv_n);
  assert_cap_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(data_edge && mem_wait_n));
  assert_end_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_last) |-> (mem_cs_n && !mem_clk));
  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);
endmodule

// File: tb/sbc_ctrl_bench.sv
module sbc_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [25:0] req_addr = '0;
  logic [7:0]  req_len_m1 = '0;
  logic [4:0]  cfg_div = 5'd2;
  logic [4:0]  cfg_lat = 5'd2;
  logic [3:0]  cfg_turn = '0;
  logic        mem_clk, mem_cs_n, mem_adv_n;
  logic [25:0] mem_addr;
  logic        mem_wait_n = 1'b1;
  logic [15:0] mem_data = '0;
  logic        rd_valid, rd_last;
  logic [15:0] rd_data;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;   // 125 MHz

  sbc_ctrl u_sbc_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len_m1(req_len_m1), .cfg_div(cfg_div),
    .cfg_lat(cfg_lat), .cfg_turn(cfg_turn), .mem_clk(mem_clk),
    .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_addr(mem_addr),
    .mem_wait_n(mem_wait_n), .mem_data(mem_data), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_last(rd_last)
  );

  function automatic int exp_div(int d);
    return (d < 2) ? 2 : ((d > 16) ? 16 : d);
  endfunction

  function automatic int exp_lat(int l);
    return (l < 2) ? 2 : ((l > 17) ? 17 : l);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_burst(int div_raw, int lat_raw, int turn, int lenm1,
                           int addr, int wpct);
    int d, h, r0, lat, cl, ncap, c;
    bit prev_cap, prev_last, done;
    int prev_data;
    d = exp_div(div_raw);
    h = d / 2;
    r0 = d - h + 1;
    lat = exp_lat(lat_raw);
    cl = -1; ncap = 0; c = 1;
    prev_cap = 0; prev_last = 0; prev_data = 0; done = 0;
    // Presented at a falling edge while ready is high; accepted at the next edge.
    req_valid = 1'b1; req_addr = 26'(addr); req_len_m1 = 8'(lenm1);
    cfg_div = 5'(div_raw); cfg_lat = 5'(lat_raw); cfg_turn = 4'(turn);
    while (!done) begin
      bit active, is_rise, w, exp_rdy;
      int k;
      @(negedge clk);
      active  = !(cl > 0 && c > cl);
      exp_rdy = (cl > 0) && (c >= cl + turn + 1);
      chk("R2 mem_clk", int'(mem_clk), active ? int'(((h + c - 1) % d) < h) : 0);
      chk("R8 mem_cs_n", int'(mem_cs_n), active ? 0 : 1);
      chk("R4 mem_adv_n", int'(mem_adv_n), (active && c <= r0 + h - 1) ? 0 : 1);
      if (active && c <= r0 + h - 1) chk("R4 mem_addr", int'(mem_addr), addr);
      chk("R9 req_ready", int'(req_ready), int'(exp_rdy));
      chk("R6 rd_valid", int'(rd_valid), int'(prev_cap));
      if (prev_cap) begin
        chk("R7 rd_data", int'(rd_data), prev_data);
        chk("R7 rd_last", int'(rd_last), int'(prev_last));
      end
      if (exp_rdy) begin
        req_valid = 1'b0;
        done = 1;
      end else begin
        // R10: disturb settings and requests while busy
        req_valid  = 1'($urandom % 2);
        req_addr   = 26'($urandom);
        req_len_m1 = 8'($urandom);
        cfg_div    = 5'($urandom);
        cfg_lat    = 5'($urandom);
        cfg_turn   = 4'($urandom);
        is_rise = active && (c >= r0) && ((c - r0) % d == 0);
        k = (c - r0) / d;
        w = int'($urandom % 100) >= wpct;
        mem_wait_n = w;
        mem_data = 16'($urandom);
        prev_cap = is_rise && (k >= lat) && w;   // R5, R6
        if (prev_cap) begin
          ncap++;
          prev_data = int'(mem_data);
          prev_last = (ncap == lenm1 + 1);
          if (prev_last) cl = c;
        end
        c++;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mem_cs_n", int'(mem_cs_n), 1);
    chk("R1 mem_adv_n", int'(mem_adv_n), 1);
    chk("R1 mem_clk", int'(mem_clk), 0);
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 rd_valid", int'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // Directed corners: smallest/odd/largest ratios and clamps (R3, R5), T=0/15 (R9)
    run_burst(2, 2, 0, 0, 26'h0000123, 0);
    run_burst(3, 2, 1, 3, 26'h1ABCDEF, 0);
    run_burst(16, 17, 15, 2, 26'h2000001, 0);
    run_burst(0, 0, 0, 1, 26'h0155555, 0);     // R3 below range, R5 below range
    run_burst(31, 31, 2, 1, 26'h3FFFFFF, 0);   // R3 above range, R5 above range
    run_burst(5, 3, 3, 4, 26'h0000F0F, 60);    // R6 heavy waits
    run_burst(4, 2, 0, 7, 26'h0ABCDE0, 30);    // R7 longer burst
    for (int i = 0; i < 30; i++) begin
      run_burst(int'($urandom % 20), int'($urandom % 20), int'($urandom % 16),
                int'($urandom % 8), int'($urandom % (1 << 26)), int'($urandom % 50));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9 act=busy exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule